// File: doc/BRIEF.md
# Issue Latency and Unit Reservation Scoreboard

This block sits beside an in-order issue stage and decides, one instruction at a time, whether the instruction offered this cycle may issue. The instruction arrives as a class code, two source register indices, a destination register index and an issue strobe. The block answers with a ready flag in the same cycle. When strobe and ready are both high, the instruction is taken, and the block records when its result becomes usable and which execution pipes it holds.

The time a result becomes usable depends on the consumer. An integer or load result used as a load address arrives later than the same result used by any other instruction. So each register keeps two down-counters: one for load-address consumers and one for all others. The condition register and the count register each have one counter of their own. Multiply, divide and store-conditional operations are not pipelined. They hold their execution pipes for a fixed number of cycles through per-pipe occupancy counters, and the busy state of the five pipes is visible on an output vector.

Class codes: 0 integer, 1 compare, 2 load, 3 wide multiply, 4 narrow divide, 5 wide divide, 6 floating-point arithmetic, 7 floating-point compare, 8 count-register write, 9 branch via count register, 10 conditional branch, 11 condition-register logical, 12 store-conditional, 13 to 15 reserved. Busy bits: [0] fixed-point, [1] load/store, [2] branch, [3] vector/FP pipe A, [4] vector/FP pipe B. Latency L means that a consumer presented L cycles after the producer's issue cycle may issue.

Top module: `sb_issue_scoreboard`

## Requirements
- R1: After reset, every class is ready with any register indices and all five busy bits are 0.
- R2: A result of class 0 (integer) or class 2 (load) becomes usable by any class other than 2 two cycles after issue.
- R3: A result of class 0 or class 2 becomes usable as a source of a class 2 (load) consumer five cycles after issue.
- R4: Class 3 (wide multiply) has a 15-cycle result latency and sets busy bits 0, 1, 3 and 4 for the 14 cycles after its issue. No class that needs one of those pipes is ready while the bit is set.
- R5: Class 4 (narrow divide) has a 32-cycle latency and holds bits 0, 1, 3 and 4 for 31 cycles. Class 5 (wide divide) has a 64-cycle latency and holds the same bits for 63 cycles.
- R6: Class 6 (floating-point) has a 10-cycle latency and holds no pipe, so independent class 6 instructions may issue on consecutive cycles.
- R7: Condition-register readers (class 10, class 11) wait 1 cycle after class 1 or class 11, 6 cycles after class 7, and 11 cycles after class 12. Class 12 also sets busy bit 1 for the 10 cycles after its issue.
- R8: Class 9 (branch via count register) becomes ready 10 cycles after a class 8 count-register write.
- R9: A strobe while ready is low has no effect on any counter.
- R10: Classes 13 to 15 are always ready and change no state when issued.
- R11: Classes 9 and 10 read no general register, so pending source indices do not hold them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue strobe for the offered instruction |
| iss_class | input | 4 | Instruction class code |
| iss_src_a | input | RW | First source register index |
| iss_src_b | input | RW | Second source register index |
| iss_dst | input | RW | Destination register index |
| iss_ready | output | 1 | Offered instruction may issue this cycle |
| unit_busy | output | 5 | Per-pipe busy flags, from occupancy counters |

## Verification
The ready flag depends on the inputs of the same cycle, so the bench samples it 1 ns after the falling edge at which it drives them. A producer taken in cycle t is expected to release its consumers in exactly cycle t+L. A pipe lock is expected to show busy in cycles t+1 through t+occupancy. The bench model stores each of these due cycles as an absolute cycle number and compares against it in every cycle, both in the directed probes that walk across each boundary and in the random stream.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int TMR_W   = 6;
  localparam int N_UNIT  = 5;
  localparam int U_FXU   = 0;
  localparam int U_LSU   = 1;
  localparam int U_BRU   = 2;
  localparam int U_VA    = 3;
  localparam int U_VB    = 4;
  localparam logic [N_UNIT-1:0] NONPIPE_MASK = 5'b11011;

  localparam logic [3:0] C_INT    = 4'd0;
  localparam logic [3:0] C_CMP    = 4'd1;
  localparam logic [3:0] C_LOAD   = 4'd2;
  localparam logic [3:0] C_MUL64  = 4'd3;
  localparam logic [3:0] C_DIV32  = 4'd4;
  localparam logic [3:0] C_DIV64  = 4'd5;
  localparam logic [3:0] C_FP     = 4'd6;
  localparam logic [3:0] C_FPCMP  = 4'd7;
  localparam logic [3:0] C_MTCTR  = 4'd8;
  localparam logic [3:0] C_BRREG  = 4'd9;
  localparam logic [3:0] C_BRCOND = 4'd10;
  localparam logic [3:0] C_CRLOG  = 4'd11;
  localparam logic [3:0] C_STCX   = 4'd12;

  // Counter preloads are latency minus one: a counter reaching zero in
  // cycle t+L releases the consumer presented in that cycle.
  typedef struct packed {
    logic              rd_src;
    logic              ld_consumer;
    logic              wr_gpr;
    logic [TMR_W-1:0]  gpr_any;
    logic [TMR_W-1:0]  gpr_ld;
    logic              wr_cr;
    logic              wr_ctr;
    logic [TMR_W-1:0]  sp_lat;
    logic              rd_cr;
    logic              rd_ctr;
    logic [N_UNIT-1:0] need;
    logic [N_UNIT-1:0] lock;
    logic [TMR_W-1:0]  occ;
  } cls_attr_t;

  function automatic cls_attr_t attr_of(input logic [3:0] c);
    cls_attr_t a;
    a = '0;
    case (c)
      C_INT, C_LOAD: begin
        a.rd_src = 1'b1; a.wr_gpr = 1'b1;
        a.gpr_any = TMR_W'(1); a.gpr_ld = TMR_W'(4);
        a.ld_consumer = (c == C_LOAD);
        a.need[(c == C_LOAD) ? U_LSU : U_FXU] = 1'b1;
      end
      C_CMP: begin
        a.rd_src = 1'b1; a.wr_cr = 1'b1; a.sp_lat = '0;
        a.need[U_FXU] = 1'b1;
      end
      C_MUL64, C_DIV32, C_DIV64: begin
        a.rd_src = 1'b1; a.wr_gpr = 1'b1;
        a.occ = (c == C_MUL64) ? TMR_W'(14) :
                (c == C_DIV32) ? TMR_W'(31) : TMR_W'(63);
        a.gpr_any = a.occ; a.gpr_ld = a.occ;
        a.need = NONPIPE_MASK; a.lock = NONPIPE_MASK;
      end
      C_FP: begin
        a.rd_src = 1'b1; a.wr_gpr = 1'b1;
        a.gpr_any = TMR_W'(9); a.gpr_ld = TMR_W'(9);
        a.need[U_VA] = 1'b1;
      end
      C_FPCMP: begin
        a.rd_src = 1'b1; a.wr_cr = 1'b1; a.sp_lat = TMR_W'(5);
        a.need[U_VA] = 1'b1;
      end
      C_MTCTR: begin
        a.rd_src = 1'b1; a.wr_ctr = 1'b1; a.sp_lat = TMR_W'(9);
        a.need[U_BRU] = 1'b1;
      end
      C_BRREG: begin
        a.rd_ctr = 1'b1; a.need[U_BRU] = 1'b1;
      end
      C_BRCOND: begin
        a.rd_cr = 1'b1; a.need[U_BRU] = 1'b1;
      end
      C_CRLOG: begin
        a.rd_cr = 1'b1; a.wr_cr = 1'b1; a.sp_lat = '0;
        a.need[U_BRU] = 1'b1;
      end
      C_STCX: begin
        a.rd_src = 1'b1; a.wr_cr = 1'b1; a.sp_lat = TMR_W'(10);
        a.need[U_LSU] = 1'b1; a.lock[U_LSU] = 1'b1; a.occ = TMR_W'(10);
      end
      default: a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/sb_countdown.sv
module sb_countdown #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] ld_val,
  output logic [TW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0));

  // R9
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sb_reg_timers.sv
module sb_reg_timers #(
  parameter int NREG = 32,
  parameter int TW   = 6,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [TW-1:0] wr_any,
  input  logic [TW-1:0] wr_ld,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  input  logic          sel_ld,
  output logic          pend_a,
  output logic          pend_b
);
  logic [TW-1:0] any_c [NREG];
  logic [TW-1:0] ld_c  [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == RW'(i));

    sb_countdown #(.TW(TW)) u_any (
      .clk(clk), .rst(rst), .load(hit), .ld_val(wr_any), .cnt(any_c[i])
    );
    sb_countdown #(.TW(TW)) u_ld (
      .clk(clk), .rst(rst), .load(hit), .ld_val(wr_ld), .cnt(ld_c[i])
    );

    // R3
    ld_ge_any_chk: assert property (@(posedge clk) disable iff (rst)
      ld_c[i] >= any_c[i]);
  end

  always_comb begin
    if (sel_ld) begin
      pend_a = (ld_c[rd_a] != '0);
      pend_b = (ld_c[rd_b] != '0);
    end else begin
      pend_a = (any_c[rd_a] != '0);
      pend_b = (any_c[rd_b] != '0);
    end
  end
endmodule

// File: rtl/sb_unit_timers.sv
module sb_unit_timers #(
  parameter int NU = 5,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [NU-1:0] lock,
  input  logic [TW-1:0] occ,
  output logic [NU-1:0] busy
);
  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic [TW-1:0] cnt;
    sb_countdown #(.TW(TW)) u_occ (
      .clk(clk), .rst(rst), .load(take && lock[u]), .ld_val(occ), .cnt(cnt)
    );
    assign busy[u] = (cnt != '0);

    // R4
    lock_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (take && lock[u] && occ != '0) |=> busy[u]);
  end
endmodule

// File: rtl/sb_issue_scoreboard.sv
module sb_issue_scoreboard
  import sb_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [3:0]        iss_class,
  input  logic [RW-1:0]     iss_src_a,
  input  logic [RW-1:0]     iss_src_b,
  input  logic [RW-1:0]     iss_dst,
  output logic              iss_ready,
  output logic [N_UNIT-1:0] unit_busy
);
  cls_attr_t   at;
  logic        pend_a, pend_b;
  logic        take;
  logic [TMR_W-1:0] cr_cnt, ctr_cnt;
  logic        cr_zero, ctr_zero;

  assign at = attr_of(iss_class);

  sb_reg_timers #(.NREG(NREG), .TW(TMR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(take && at.wr_gpr), .wr_idx(iss_dst),
    .wr_any(at.gpr_any), .wr_ld(at.gpr_ld),
    .rd_a(iss_src_a), .rd_b(iss_src_b), .sel_ld(at.ld_consumer),
    .pend_a(pend_a), .pend_b(pend_b)
  );

  sb_countdown #(.TW(TMR_W)) u_cr (
    .clk(clk), .rst(rst), .load(take && at.wr_cr), .ld_val(at.sp_lat), .cnt(cr_cnt)
  );
  sb_countdown #(.TW(TMR_W)) u_ctr (
    .clk(clk), .rst(rst), .load(take && at.wr_ctr), .ld_val(at.sp_lat), .cnt(ctr_cnt)
  );
  assign cr_zero  = (cr_cnt == '0);
  assign ctr_zero = (ctr_cnt == '0);

  sb_unit_timers #(.NU(N_UNIT), .TW(TMR_W)) u_units (
    .clk(clk), .rst(rst), .take(take), .lock(at.lock), .occ(at.occ),
    .busy(unit_busy)
  );

  always_comb begin
    iss_ready = 1'b1;
    if (at.rd_src && (pend_a || pend_b)) iss_ready = 1'b0;
    if (at.rd_cr && !cr_zero)            iss_ready = 1'b0;
    if (at.rd_ctr && !ctr_zero)          iss_ready = 1'b0;
    if ((at.need & unit_busy) != '0)     iss_ready = 1'b0;
  end

  assign take = iss_valid && iss_ready;

  // R4
  mul_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (take && iss_class == C_MUL64) |=>
      (unit_busy[U_FXU] && unit_busy[U_LSU] && unit_busy[U_VA] && unit_busy[U_VB]));

  // R7
  fpcmp_cr_chk: assert property (@(posedge clk) disable iff (rst)
    (take && iss_class == C_FPCMP) |=> !cr_zero);

  // R8
  ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (take && iss_class == C_MTCTR) |=> !ctr_zero);

  // R10
  reserved_free_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_class > C_STCX) |-> iss_ready);
endmodule

// File: tb/tb_sb_issue_scoreboard.sv
`timescale 1ns/1ps
module tb_sb_issue_scoreboard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iss_valid = 1'b0;
  logic [3:0] iss_class = '0;
  logic [4:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic       iss_ready;
  logic [4:0] unit_busy;

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  longint cyc = 0;
  longint due_any [32];
  longint due_ld  [32];
  longint cr_due, ctr_due;
  longint unit_end [5];

  always #4 clk = ~clk;

  sb_issue_scoreboard #(.NREG(32)) dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .iss_ready(iss_ready), .unit_busy(unit_busy)
  );

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic bit reads_src(int c);
    return c inside {0, 1, 2, 3, 4, 5, 6, 7, 8, 12};
  endfunction

  function automatic int need_mask(int c);
    case (c)
      0, 1:    return 1;
      2, 12:   return 2;
      3, 4, 5: return 27;
      6, 7:    return 8;
      8, 9, 10, 11: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_ready(int c, int a, int b);
    bit r = 1;
    if (reads_src(c)) begin
      if (c == 2) begin
        if (cyc < due_ld[a] || cyc < due_ld[b]) r = 0;
      end else begin
        if (cyc < due_any[a] || cyc < due_any[b]) r = 0;
      end
    end
    if ((c == 10 || c == 11) && cyc < cr_due) r = 0;
    if (c == 9 && cyc < ctr_due) r = 0;
    for (int u = 0; u < 5; u++)
      if (need_mask(c)[u] && cyc <= unit_end[u]) r = 0;
    return r;
  endfunction

  function automatic logic [4:0] exp_busy();
    logic [4:0] v;
    for (int u = 0; u < 5; u++) v[u] = (cyc <= unit_end[u]);
    return v;
  endfunction

  function automatic void lock_np(int occ);
    unit_end[0] = cyc + occ; unit_end[1] = cyc + occ;
    unit_end[3] = cyc + occ; unit_end[4] = cyc + occ;
  endfunction

  function automatic void model_issue(int c, int d);
    case (c)
      0, 2: begin due_any[d] = cyc + 2;  due_ld[d] = cyc + 5;  end
      3:    begin due_any[d] = cyc + 15; due_ld[d] = cyc + 15; lock_np(14); end
      4:    begin due_any[d] = cyc + 32; due_ld[d] = cyc + 32; lock_np(31); end
      5:    begin due_any[d] = cyc + 64; due_ld[d] = cyc + 64; lock_np(63); end
      6:    begin due_any[d] = cyc + 10; due_ld[d] = cyc + 10; end
      1, 11: cr_due = cyc + 1;
      7:    cr_due = cyc + 6;
      12:   begin cr_due = cyc + 11; unit_end[1] = cyc + 10; end
      8:    ctr_due = cyc + 10;
      default: ;
    endcase
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      1, 7, 11, 12: return "R7";
      8: return "R8";
      9, 10: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check(int got, int exp, string tag, string what);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, exp);
    end
  endtask

  task automatic step(int c, int a, int b, int d, bit v, string tag);
    bit er;
    @(negedge clk);
    iss_valid = v; iss_class = c[3:0];
    iss_src_a = a[4:0]; iss_src_b = b[4:0]; iss_dst = d[4:0];
    #1;
    er = exp_ready(c, a, b);
    check(int'(iss_ready), int'(er), tag, "ready");
    check(int'(unit_busy), int'(exp_busy()), tag, "busy");
    if (v && er) model_issue(c, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int r, c;
    void'($urandom(32'd7715));
    for (int i = 0; i < 32; i++) begin due_any[i] = 0; due_ld[i] = 0; end
    cr_due = 0; ctr_due = 0;
    for (int u = 0; u < 5; u++) unit_end[u] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: every class ready, nothing busy, straight after reset
    for (int k = 0; k < 16; k++) step(k, k, 31 - k, 1, 0, "R1");

    // R3 then R2: integer result into load address vs plain use
    step(0, 1, 2, 5, 1, "R2");
    for (int k = 0; k < 6; k++) step(2, 5, 0, 9, 0, "R3");
    step(2, 1, 1, 6, 1, "R3");
    for (int k = 0; k < 3; k++) step(0, 6, 0, 9, 0, "R2");
    for (int k = 0; k < 6; k++) step(2, 6, 0, 9, 0, "R3");

    // R9: rejected strobe leaves destination untouched
    step(0, 1, 1, 12, 1, "R2");
    step(0, 12, 1, 14, 1, "R9");
    step(6, 14, 14, 15, 0, "R9");

    // R11: conditional branch ignores pending sources
    step(0, 1, 1, 3, 1, "R2");
    step(10, 3, 3, 3, 0, "R11");
    step(9, 3, 3, 3, 0, "R11");

    // R4: multiply locks pipes, result at 15
    step(3, 1, 2, 7, 1, "R4");
    for (int k = 0; k < 16; k++) step(0, 1, 1, 9, 0, "R4");
    step(12, 1, 1, 9, 1, "R9");
    step(10, 1, 1, 1, 0, "R9");
    for (int k = 0; k < 2; k++) step(6, 7, 7, 9, 0, "R4");

    // R5: narrow and wide divide
    step(4, 1, 2, 8, 1, "R5");
    for (int k = 0; k < 33; k++) step(0, 8, 8, 9, 0, "R5");
    step(5, 1, 2, 10, 1, "R5");
    for (int k = 0; k < 65; k++) step(6, 10, 1, 9, 0, "R5");

    // R6: back to back floating point, result at 10
    step(6, 1, 2, 16, 1, "R6");
    step(6, 1, 2, 17, 1, "R6");
    for (int k = 0; k < 10; k++) step(0, 16, 17, 9, 0, "R6");

    // R7: condition register delays
    step(7, 1, 2, 0, 1, "R7");
    for (int k = 0; k < 7; k++) step(10, 0, 0, 0, 0, "R7");
    step(12, 1, 2, 0, 1, "R7");
    for (int k = 0; k < 12; k++) step(11, 0, 0, 0, 0, "R7");
    step(2, 1, 1, 9, 0, "R7");
    step(1, 1, 2, 0, 1, "R7");
    for (int k = 0; k < 2; k++) step(10, 0, 0, 0, 0, "R7");

    // R8: count register write to branch via register
    step(8, 1, 1, 0, 1, "R8");
    for (int k = 0; k < 11; k++) step(9, 0, 0, 0, 0, "R8");

    // R10: reserved classes
    step(3, 1, 2, 18, 1, "R4");
    step(13, 18, 18, 18, 1, "R10");
    step(15, 18, 18, 19, 1, "R10");
    step(6, 19, 19, 9, 0, "R10");
    for (int k = 0; k < 14; k++) step(0, 1, 1, 9, 0, "R4");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      r = int'($urandom % 100);
      if      (r < 2)  c = 5;
      else if (r < 5)  c = 4;
      else if (r < 9)  c = 3;
      else if (r < 12) c = 13 + int'($urandom % 3);
      else             c = int'($urandom % 13);
      if (c inside {3, 4, 5} && (n % 4) != 0) c = 0;
      step(c, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
           ($urandom % 10) < 7, tag_of(c));
    end

    @(negedge clk);
    iss_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule